// File: doc/BRIEF.md
# Indexed Multiply with Memory Fetch

This block computes one signed 32-bit product per call. The product is a scalar operand times one word read from external memory. The caller gives the operand, a byte base address and a signed element index through a start/busy call interface. The block latches them, issues one read on a memory-mapped read port and waits one cycle for the word. It multiplies and then presents the result on a done/stall return interface.

Both edges of the block follow a valid/ready style of flow control. On the call side, start acts as valid and the inverse of busy acts as ready. A call is taken only in a cycle where start is high and busy is low. While busy is high, the caller keeps start and the arguments steady. On the return side, done acts as valid and the inverse of stall acts as ready. The result is handed off only in a cycle where done is high and stall is low. Until then, done and the result stay where they are. The read port has no wait signal, so every request is taken in the cycle it is issued. Only one call is in flight at a time.

Top module: `idxmul_core`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, with busy, done and mem_rd all low in the cycle after reset is sampled. This holds even when a call is in progress.
- R2: A call is accepted at a clock edge where start is high and busy is low. busy goes high in the very next cycle.
- R3: The read address is arg_base plus four times arg_index. The index is taken as signed two's complement, and the sum wraps at the address width.
- R4: Each call produces exactly one read request. The request is mem_rd high for a single cycle: the first cycle after acceptance.
- R5: mem_rdata is sampled in the cycle after the request. done rises in that sample cycle plus one, which is the third cycle after acceptance.
- R6: result equals the low 32 bits of the signed product of arg_scale and the fetched word.
- R7: While done is high and stall is high, done stays high and result stays unchanged.
- R8: busy stays high until a cycle with done high and stall low. In the next cycle, busy and done are both low.
- R9: If start stays high while busy is high, no further read is issued and no second call begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Call request (valid) |
| busy | output | 1 | Call side not ready; hold start and arguments |
| arg_scale | input | 32 | Signed scalar operand |
| arg_base | input | 32 | Byte base address of the element array |
| arg_index | input | 32 | Signed element index |
| mem_rd | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 32 | Read word, valid one cycle after mem_rd |
| done | output | 1 | Result valid |
| stall | input | 1 | Downstream not ready; hold result |
| result | output | 32 | Low 32 bits of the product |

## Verification
The hardest case to reach from the ports is a result held through a long stall while start is still high. In that case the block must neither issue a second read nor let the held value drift. The random calls keep start high for the whole call and apply stall runs of random length, including zero. At every cycle of the hold, the bench checks that done and result have not moved. Directed calls add a negative index, operands that overflow the product, and a reset in the middle of a call.

// File: rtl/idxmul_pkg.sv
package idxmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } idxmul_st_e;
endpackage

// File: rtl/idxmul_ctrl.sv
module idxmul_ctrl
  import idxmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stall,
  output idxmul_st_e st,
  output logic       accept,
  output logic       capture
);
  idxmul_st_e st_q, st_d;

  assign accept  = (st_q == ST_IDLE) && start;
  assign capture = (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)  st_d = ST_READ;
      ST_READ:             st_d = ST_WAIT;
      ST_WAIT:             st_d = ST_DONE;
      ST_DONE: if (!stall) st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/idxmul_addr.sv
module idxmul_addr #(
  parameter int AW         = 32,
  parameter int IW         = 32,
  parameter int ELEM_BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] index,
  output logic [AW-1:0] addr
);
  localparam int SHIFT = $clog2(ELEM_BYTES);
  logic [AW-1:0] idx_ext;

  generate
    if (IW >= AW) begin : g_trunc
      assign idx_ext = index[AW-1:0];
    end else begin : g_sext
      assign idx_ext = {{(AW-IW){index[IW-1]}}, index};
    end
  endgenerate

  assign addr = base + (idx_ext << SHIFT);
endmodule

// File: rtl/idxmul_mult.sv
module idxmul_mult #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] prod
);
  logic [DW-1:0] prod_lo;
  logic [DW-1:0] prod_q;

  // Low DW bits of a product do not depend on operand signedness.
  assign prod_lo = opa * opb;

  always_ff @(posedge clk) begin
    if (rst)          prod_q <= '0;
    else if (capture) prod_q <= prod_lo;
  end

  assign prod = prod_q;
endmodule

// File: rtl/idxmul_core.sv
module idxmul_core
  import idxmul_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int IW         = 32,
  parameter int ELEM_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  input  logic [DW-1:0] arg_scale,
  input  logic [AW-1:0] arg_base,
  input  logic [IW-1:0] arg_index,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  input  logic          stall,
  output logic [DW-1:0] result
);
  idxmul_st_e    st;
  logic          accept, capture;
  logic [DW-1:0] scale_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] index_q;

  idxmul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stall(stall),
    .st(st), .accept(accept), .capture(capture)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q <= '0;
      base_q  <= '0;
      index_q <= '0;
    end else if (accept) begin
      scale_q <= arg_scale;
      base_q  <= arg_base;
      index_q <= arg_index;
    end
  end

  idxmul_addr #(.AW(AW), .IW(IW), .ELEM_BYTES(ELEM_BYTES)) u_addr (
    .base(base_q), .index(index_q), .addr(mem_addr)
  );

  idxmul_mult #(.DW(DW)) u_mult (
    .clk(clk), .rst(rst), .capture(capture),
    .opa(scale_q), .opb(mem_rdata), .prod(result)
  );

  assign busy   = (st != ST_IDLE);
  assign mem_rd = (st == ST_READ);
  assign done   = (st == ST_DONE);
endmodule

// File: rtl/idxmul_chk.sv
module idxmul_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          mem_rd,
  input logic          done,
  input logic          stall,
  input logic [DW-1:0] result
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_rd));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R4
  read_in_call_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R5
  read_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (!done && busy));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && stall) |=> (done && $stable(result)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(done && !stall)) |=> busy);

  // R8
  handoff_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !stall) |=> (!busy && !done));

  // R9
  no_extra_read_chk: assert property (@(posedge clk) disable iff (rst)
    (done || (busy && !mem_rd && !done)) |-> !mem_rd);
endmodule

bind idxmul_core idxmul_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .mem_rd(mem_rd),
  .done(done), .stall(stall), .result(result)
);

// File: tb/tb_idxmul_core.sv
`timescale 1ns/1ps
module tb_idxmul_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] arg_scale = '0, arg_base = '0, arg_index = '0;
  logic [31:0] mem_rdata = '0;
  logic        busy, mem_rd, done;
  logic [31:0] mem_addr, result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  idxmul_core dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .arg_scale(arg_scale), .arg_base(arg_base), .arg_index(arg_index),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .stall(stall), .result(result)
  );

  function automatic logic [31:0] memval(input logic [31:0] a);
    return ((a ^ 32'hA5A5_0F0F) * 32'h0001_0003) + 32'd7;
  endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[31:0];
  endfunction

  // Memory model: one cycle read latency, no wait.
  always @(posedge clk) if (mem_rd) mem_rdata <= memval(mem_addr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_call(input logic [31:0] s, input logic [31:0] b,
                         input logic [31:0] ix, input int nstall);
    logic [31:0] ea, ev;
    ea = b + ix * 32'd4;
    ev = ref_mul(s, memval(ea));
    @(negedge clk);
    chk(!busy, "R2 idle before call", {31'd0, busy}, 32'd0);
    start = 1'b1; arg_scale = s; arg_base = b; arg_index = ix;
    @(negedge clk);
    chk(busy, "R2 busy after accept", {31'd0, busy}, 32'd1);
    chk(mem_rd, "R4 read strobe", {31'd0, mem_rd}, 32'd1);
    chk(mem_addr == ea, "R3 address", mem_addr, ea);
    @(negedge clk);
    chk(!mem_rd && busy && !done, "R9 no second read", {29'd0, mem_rd, busy, done}, 32'd2);
    @(negedge clk);
    chk(done, "R5 done timing", {31'd0, done}, 32'd1);
    chk(result == ev, "R6 product", result, ev);
    chk(!mem_rd, "R9 no read while done", {31'd0, mem_rd}, 32'd0);
    if (nstall > 0) stall = 1'b1;
    for (int i = 0; i < nstall; i++) begin
      @(negedge clk);
      chk(done && result == ev, "R7 hold under stall", result, ev);
      chk(busy && !mem_rd, "R8 busy held", {30'd0, busy, mem_rd}, 32'd2);
      if (i == nstall - 1) stall = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R8 idle after handoff", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1 reset state", {29'd0, busy, done, mem_rd}, 32'd0);
    rst = 1'b0;
    // Directed corners
    do_call(32'd3, 32'h0000_1000, 32'd0, 0);
    do_call(32'hFFFF_FFFF, 32'h0000_2000, 32'hFFFF_FFFF, 2);   // negative index
    do_call(32'h8000_0000, 32'h0000_0400, 32'd5, 1);           // overflow
    do_call(32'd0, 32'h0000_0800, 32'd17, 0);
    do_call(32'h7FFF_FFFF, 32'hFFFF_FFF0, 32'd8, 9);            // address wrap, long stall
    // Reset in the middle of a call
    @(negedge clk);
    start = 1'b1; arg_scale = 32'd9; arg_base = 32'h100; arg_index = 32'd2;
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1 mid-call reset", {29'd0, busy, done, mem_rd}, 32'd0);
    rst = 1'b0;
    // Random calls
    for (int n = 0; n < 150; n++) begin
      logic [31:0] rs, rb, ri;
      int st;
      rs = $urandom();
      rb = {$urandom_range(0, 32'hFFFF), 2'b00};
      ri = 32'($signed($urandom_range(0, 512)) - 256);
      st = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 12));
      do_call(rs, rb, ri, st);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule